// File: doc/BRIEF.md
# Grouped carry-lookahead adder

A purely combinational binary adder that splits its operands into equal slices. Inside a slice, every carry is formed directly from per-bit generate and propagate terms in a flat sum of products, so no carry has to ripple from bit to bit. The carry leaving one slice becomes the carry entering the next one, so the slices are chained in series. The default build is 16 bits wide with four slices of four bits.

The block takes two operands and a carry-in and returns the sum and a carry-out in the same cycle. It has no clock and no state. Total width and slice size are parameters. A slice size that does not divide the width, or that is wider than the fan-in the lookahead terms are meant to have, stops elaboration.

Top module: `cla_adder`

## Requirements
- R1: For each bit, the generate term is the AND of the two operand bits and the propagate term is their OR. A bit whose generate is set always has its propagate set.
- R2: Sum bit i is the XOR of operand bit i of a_i, operand bit i of b_i and the carry into bit i. It does not reuse the OR-based propagate term.
- R3: Inside a slice, the carry into each position comes from a two-level expansion over the generate and propagate terms of the lower positions and the slice carry-in. It matches the recurrence carry(i+1) = g(i) | (p(i) & carry(i)).
- R4: The carry out of slice k is the carry into slice k+1. A carry entering at bit 0 crosses every slice boundary when all bits propagate (0xFFFF + 0 + 1 gives sum 0x0000, carry-out 1).
- R5: carry_o is the carry out of the most significant bit. It is 1 whenever both top operand bits are 1 and 0 whenever both are 0.
- R6: {carry_o, sum_o} equals a_i + b_i + carry_i for every input combination.
- R7: WIDTH must be a multiple of GROUP, and GROUP must lie between 1 and 8; otherwise elaboration fails. The block works at any legal width, including WIDTH=8 with GROUP=4.
- R8: The block is combinational. Outputs follow a change on the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
An 8-bit build is driven through every operand pair with both carry-in values. This exposes any wrong product term in the lookahead expansion and any fault in the single slice boundary.

The 16-bit build gets directed vectors, then random ones:
- all-ones plus carry-in, and alternating-bit operands, which make a carry travel through every slice boundary;
- operands that only generate, which separate generate from propagate;
- operands that only propagate, which show whether the sum wrongly reuses the OR term;
- carries that stay inside one slice;
- carries out of the top bit.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // widest slice the flat lookahead terms are meant for (fan-in bound)
  localparam int unsigned MAX_GROUP = 8;

  function automatic bit split_ok(int unsigned width, int unsigned group);
    return (group >= 1) && (group <= MAX_GROUP) && (width >= group) && ((width % group) == 0);
  endfunction
endpackage

// File: rtl/cla_gen_prop.sv
module cla_gen_prop #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);
  assign gen_o  = a_i & b_i;
  assign prop_o = a_i | b_i;

  always_comb begin
    if (!$isunknown({gen_o, prop_o}))
      p_gen_implies_prop_r1: assert ((gen_o & ~prop_o) == '0)
        else $error("R1: generate set without propagate");
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GROUP = 4
) (
  input  logic [GROUP-1:0] gen_i,
  input  logic [GROUP-1:0] prop_i,
  input  logic             carry_i,
  output logic [GROUP:0]   carry_o
);
  // carry_o[k]: carry into slice position k; carry_o[GROUP]: slice carry-out
  always_comb begin
    carry_o[0] = carry_i;
    for (int k = 1; k <= GROUP; k++) begin
      logic acc;
      logic prod;
      prod = carry_i;
      for (int m = 0; m < k; m++) prod = prod & prop_i[m];
      acc = prod;
      for (int j = 0; j < k; j++) begin
        prod = gen_i[j];
        for (int m = j + 1; m < k; m++) prod = prod & prop_i[m];
        acc = acc | prod;
      end
      carry_o[k] = acc;
    end
  end

  always_comb begin
    if (!$isunknown({gen_i, prop_i, carry_i, carry_o}))
      for (int k = 0; k < GROUP; k++)
        p_carry_recur_r3: assert (carry_o[k+1] == (gen_i[k] | (prop_i[k] & carry_o[k])))
          else $error("R3: lookahead carry %0d breaks recurrence", k + 1);
  end
endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o
);
  // three-input XOR; the OR-based propagate cannot stand in for a^b
  assign sum_o = a_i ^ b_i ^ carry_i;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned GROUP = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  import cla_pkg::*;

  localparam int unsigned NUM_GROUPS = WIDTH / GROUP;

  if (!split_ok(WIDTH, GROUP)) begin : g_bad_split
    $error("R7: WIDTH %0d is not a legal multiple of GROUP %0d", WIDTH, GROUP);
  end

  logic [WIDTH-1:0]    gen;
  logic [WIDTH-1:0]    prop;
  logic [WIDTH-1:0]    bit_carry;
  logic [NUM_GROUPS:0] grp_carry;

  cla_gen_prop #(.WIDTH(WIDTH)) u_gen_prop (
    .a_i   (a_i),
    .b_i   (b_i),
    .gen_o (gen),
    .prop_o(prop)
  );

  assign grp_carry[0] = carry_i;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    logic [GROUP:0] c;
    cla_group #(.GROUP(GROUP)) u_group (
      .gen_i  (gen[k*GROUP +: GROUP]),
      .prop_i (prop[k*GROUP +: GROUP]),
      .carry_i(grp_carry[k]),
      .carry_o(c)
    );
    assign bit_carry[k*GROUP +: GROUP] = c[GROUP-1:0];
    assign grp_carry[k+1]              = c[GROUP];
  end

  cla_sum #(.WIDTH(WIDTH)) u_sum (
    .a_i    (a_i),
    .b_i    (b_i),
    .carry_i(bit_carry),
    .sum_o  (sum_o)
  );

  assign carry_o = grp_carry[NUM_GROUPS];

  always_comb begin
    if (!$isunknown({a_i, b_i, carry_i, sum_o, carry_o})) begin
      p_total_sum_r6: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}))
        else $error("R6: sum mismatch");
      p_cout_gen_r5: assert (!(a_i[WIDTH-1] && b_i[WIDTH-1]) || carry_o)
        else $error("R5: top generate lost");
      p_cout_kill_r5: assert (a_i[WIDTH-1] || b_i[WIDTH-1] || !carry_o)
        else $error("R5: carry-out through killed top bit");
      p_sum_xor_r2: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ carry_i))
        else $error("R2: low sum bit wrong");
    end
  end
endmodule

// File: tb/cla_adder_bench.sv
module cla_adder_bench;
  localparam int unsigned W16 = 16;
  localparam int unsigned W8  = 8;
  localparam int unsigned WATCHDOG = 190000;

  typedef struct {
    logic [W16:0] exp;
    logic [W16:0] a_cp;
    logic [W16:0] b_cp;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [W16-1:0] a16, b16, s16;
  logic           c16_in, c16_out;
  logic [W8-1:0]  a8, b8, s8;
  logic           c8_in, c8_out;

  int total = 0;
  int fails = 0;
  item_t q16[$];
  item_t q8[$];

  cla_adder #(.WIDTH(W16), .GROUP(4)) u_cla_adder (
    .a_i(a16), .b_i(b16), .carry_i(c16_in), .sum_o(s16), .carry_o(c16_out)
  );

  cla_adder #(.WIDTH(W8), .GROUP(4)) u_cla_adder_w8 (
    .a_i(a8), .b_i(b8), .carry_i(c8_in), .sum_o(s8), .carry_o(c8_out)
  );

  task automatic drive16(input logic [W16-1:0] a, input logic [W16-1:0] b, input logic ci, input string tag);
    item_t it;
    @(posedge clk);
    a16 = a; b16 = b; c16_in = ci;
    it.exp  = {1'b0, a} + {1'b0, b} + {{W16{1'b0}}, ci};
    it.a_cp = {1'b0, a};
    it.b_cp = {1'b0, b};
    it.tag  = tag;
    q16.push_back(it);
  endtask

  task automatic drive8(input logic [W8-1:0] a, input logic [W8-1:0] b, input logic ci);
    item_t it;
    @(posedge clk);
    a8 = a; b8 = b; c8_in = ci;
    it.exp  = {9'd0, a} + {9'd0, b} + {{W16{1'b0}}, ci};
    it.a_cp = {9'd0, a};
    it.b_cp = {9'd0, b};
    it.tag  = "R6 R7 exhaustive";
    q8.push_back(it);
  endtask

  // monitors: results sampled mid-cycle, half a period after the drive (R8)
  always @(negedge clk) begin
    if (q16.size() > 0) begin
      item_t it;
      it = q16.pop_front();
      total++;
      if ({c16_out, s16} !== it.exp[W16:0]) begin
        fails++;
        $display("FAIL %s: a=%h b=%h actual=%h expected=%h", it.tag, it.a_cp[W16-1:0],
                 it.b_cp[W16-1:0], {c16_out, s16}, it.exp[W16:0]);
      end
    end
    if (q8.size() > 0) begin
      item_t it;
      it = q8.pop_front();
      total++;
      if ({c8_out, s8} !== it.exp[W8:0]) begin
        fails++;
        $display("FAIL %s: a=%h b=%h actual=%h expected=%h", it.tag, it.a_cp[W8-1:0],
                 it.b_cp[W8-1:0], {c8_out, s8}, it.exp[W8:0]);
      end
    end
  end

  task automatic run16();
    drive16(16'h1234, 16'h1234, 1'b0, "R1 generate-only");
    drive16(16'h0F0F, 16'hF0F0, 1'b0, "R2 propagate-only no carry");
    drive16(16'h0F0F, 16'hF0F0, 1'b1, "R2 propagate-only with carry");
    drive16(16'h0007, 16'h0001, 1'b0, "R3 carry inside slice");
    drive16(16'h0006, 16'h0001, 1'b1, "R3 carry-in into slice");
    drive16(16'hFFFF, 16'h0000, 1'b1, "R4 all-ones plus carry-in");
    drive16(16'hFFFF, 16'hFFFF, 1'b1, "R4 all-ones both plus carry-in");
    drive16(16'hAAAA, 16'h5555, 1'b1, "R4 alternating ripple");
    drive16(16'h000F, 16'h0001, 1'b0, "R4 slice boundary");
    drive16(16'h0FFF, 16'h0001, 1'b0, "R4 third boundary");
    drive16(16'h8000, 16'h8000, 1'b0, "R5 top generate");
    drive16(16'h7FFF, 16'h0000, 1'b1, "R5 no carry-out");
    drive16(16'hFFFF, 16'hFFFF, 1'b0, "R5 all-ones no carry-in");
    for (int n = 0; n < 3000; n++)
      drive16(16'($urandom), 16'($urandom), 1'($urandom), "R6 random");
  endtask

  task automatic run8();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          drive8(8'(a), 8'(b), 1'(c));
  endtask

  initial begin
    a16 = '0; b16 = '0; c16_in = 1'b0;
    a8 = '0; b8 = '0; c8_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    total++;
    if ({c16_out, s16} !== '0) begin
      fails++;
      $display("FAIL R6 idle zero inputs: actual=%h expected=%h", {c16_out, s16}, 17'h0);
    end
    rst_ni = 1'b1;
    fork
      begin
        fork
          run16();
          run8();
        join
        repeat (3) @(posedge clk);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R8 watchdog: actual cycles=%0d expected below=%0d", WATCHDOG, WATCHDOG);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule